// File: doc/BRIEF.md
# Two-Lane Shift-Mask-Add Interpolator

This block is a small arithmetic unit on a register bus. It holds two 32-bit accumulators, three 32-bit bases and one configuration word per lane. Each lane takes an accumulator, which is its own or the other lane's. The lane shifts that value right by a logical shift and keeps a chosen bit field. It can sign-extend the field, and it then adds the lane's base. A third result adds base 2 to the base-free outputs of both lanes. Software steps through tables or texture coordinates by reading results and folding them back into the accumulators.

There are two read flavours. A peek returns a result and changes nothing. A pop returns the same value and, on the same clock edge, reloads both accumulators from the lane results. The bus also offers add ports, which add a 24-bit value to an accumulator in a single access. A paired base port loads base 0 and base 1 in one write. Each lane has its own settings for cross-lane input, cross-lane writeback, forced high result bits and overflow flags.

Top module: `interp2_top`

## Requirements
- R1: After synchronous reset, every accumulator, base and configuration field is zero, `rsp_valid` is low and every bus address reads zero.
- R2: Word address map (`req_addr`): 0/1 accumulator 0/1, 2/3/4 base 0/1/2, 5/6/7 pop result 0/1/2, 8/9/10 peek result 0/1/2, 11/12 lane 0/1 configuration, 13/14 add port of accumulator 0/1, 15 paired base port. Accumulators and bases read back what was written. A configuration read returns bits [20:0] as written, with bits [22:21] and [31:26] reading zero. An add port reads as its accumulator, and the paired base port reads zero.
- R3: Configuration fields: bits [4:0] give the right-shift amount, [9:5] the lowest kept bit and [14:10] the highest kept bit, both inclusive. The lane output is the shifted input with every bit outside that range cleared, so a lowest index above the highest keeps nothing. The lane result is base plus lane output, modulo 2^32.
- R4: With bit [15] set, a lane output whose highest kept bit is 1 has all bits above that position set to 1.
- R5: With bit [16] set, the lane uses the other lane's accumulator as its input.
- R6: With bit [17] set, a pop loads this lane's accumulator with the other lane's result instead of its own.
- R7: With bit [18] set on lane 0, the lane 0 output is its raw input, with no shift and no mask. Bit [18] has no effect on lane 1.
- R8: Bits [20:19] of a lane configuration are ORed into bits [29:28] of that lane's result as read on the bus. They are not applied to the value that a pop writes back, and not to result 2.
- R9: Every configuration read shows bit [23] when lane 0's shifted input has a 1 above its highest kept bit, and bit [24] for lane 1 on the same rule. Bit [25] is the OR of the two.
- R10: A pop read of any of the three results returns the value computed from the state before the access. At that request edge it loads both accumulators with their lane results. A peek read changes no state.
- R11: Result 2 equals base 2 plus the lane 0 output plus the lane 1 output, modulo 2^32.
- R12: A write to an add port adds write data bits [23:0], zero-extended, to that accumulator, modulo 2^32. The upper data bits are ignored.
- R13: A write to the paired base port loads base 0 with data bits [15:0] and base 1 with bits [31:16], both zero-extended, on the same edge.
- R14: Every read request gets exactly one response on the following clock edge, with `rsp_valid` high and the data in `rsp_rdata`. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus access in this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 4 | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |

## Verification
Read data arrives on the edge after the read request. State changes from writes, add ports and pops take effect on the request edge itself, so an access issued in the next cycle already sees them. The bench issues at most one access per falling edge. For each read it queues the value computed from its own model of the state before the access. A monitor compares the queue head at the falling edge after the response edge, and flags any response that arrives with nothing queued.

// File: rtl/interp2_pkg.sv
package interp2_pkg;

    localparam int DATA_W    = 32;
    localparam int SH_W      = $clog2(DATA_W);
    localparam int ADDR_W    = 4;
    localparam int ADD_W     = 24;
    localparam int HALF_W    = DATA_W / 2;
    localparam int FORCE_POS = 28;
    localparam int OVF0_POS  = 23;
    localparam int OVF1_POS  = 24;
    localparam int OVFA_POS  = 25;

    // Field order fixes the bit positions software programs.
    typedef struct packed {
        logic [1:0]      force_hi;
        logic            raw_add;
        logic            xres;
        logic            xin;
        logic            sext;
        logic [SH_W-1:0] top;
        logic [SH_W-1:0] bot;
        logic [SH_W-1:0] shamt;
    } lane_cfg_t;

    localparam int CFG_W = $bits(lane_cfg_t);

    typedef enum logic [ADDR_W-1:0] {
        A_ACC0   = 4'd0,
        A_ACC1   = 4'd1,
        A_BASE0  = 4'd2,
        A_BASE1  = 4'd3,
        A_BASE2  = 4'd4,
        A_POP0   = 4'd5,
        A_POP1   = 4'd6,
        A_POP2   = 4'd7,
        A_PEEK0  = 4'd8,
        A_PEEK1  = 4'd9,
        A_PEEK2  = 4'd10,
        A_CFG0   = 4'd11,
        A_CFG1   = 4'd12,
        A_ADD0   = 4'd13,
        A_ADD1   = 4'd14,
        A_BASE01 = 4'd15
    } reg_sel_e;

    typedef struct packed {
        logic       acc_wr;
        logic       add_wr;
        logic       base_wr;
        logic       cfg_wr;
        logic       split_wr;
        logic       pop;
        logic [1:0] sel;
    } bus_cmd_t;

    function automatic bus_cmd_t decode_req(input logic v, input logic w,
                                            input logic [ADDR_W-1:0] a);
        bus_cmd_t c;
        c = '0;
        if (v && w) begin
            unique case (reg_sel_e'(a))
                A_ACC0:   begin c.acc_wr  = 1'b1; c.sel = 2'd0; end
                A_ACC1:   begin c.acc_wr  = 1'b1; c.sel = 2'd1; end
                A_BASE0:  begin c.base_wr = 1'b1; c.sel = 2'd0; end
                A_BASE1:  begin c.base_wr = 1'b1; c.sel = 2'd1; end
                A_BASE2:  begin c.base_wr = 1'b1; c.sel = 2'd2; end
                A_CFG0:   begin c.cfg_wr  = 1'b1; c.sel = 2'd0; end
                A_CFG1:   begin c.cfg_wr  = 1'b1; c.sel = 2'd1; end
                A_ADD0:   begin c.add_wr  = 1'b1; c.sel = 2'd0; end
                A_ADD1:   begin c.add_wr  = 1'b1; c.sel = 2'd1; end
                A_BASE01: c.split_wr = 1'b1;
                default:  c = '0;
            endcase
        end else if (v) begin
            c.pop = (reg_sel_e'(a) == A_POP0) || (reg_sel_e'(a) == A_POP1) ||
                    (reg_sel_e'(a) == A_POP2);
        end
        return c;
    endfunction

    // Bits lo..hi inclusive; empty when lo > hi.
    function automatic logic [DATA_W-1:0] span_mask(input logic [SH_W-1:0] lo,
                                                    input logic [SH_W-1:0] hi);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < DATA_W; i++)
            m[i] = (i >= int'(lo)) && (i <= int'(hi));
        return m;
    endfunction

    // Bits strictly above hi.
    function automatic logic [DATA_W-1:0] above_mask(input logic [SH_W-1:0] hi);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < DATA_W; i++)
            m[i] = (i > int'(hi));
        return m;
    endfunction

endpackage

// File: rtl/interp2_lane.sv
module interp2_lane
    import interp2_pkg::*;
#(
    parameter int DW     = DATA_W,
    parameter bit RAW_OK = 1'b0
) (
    input  lane_cfg_t       cfg,
    input  logic [DW-1:0]   acc_own,
    input  logic [DW-1:0]   acc_opp,
    input  logic [DW-1:0]   base,
    output logic [DW-1:0]   contrib,
    output logic [DW-1:0]   result,
    output logic            ovf
);

    logic [DW-1:0] src;
    logic [DW-1:0] shifted;
    logic [DW-1:0] picked;
    logic [DW-1:0] high;
    logic          raw_sel;

    // Only the lane built with RAW_OK honours the raw-add bit.
    if (RAW_OK) begin : g_raw
        assign raw_sel = cfg.raw_add;
    end else begin : g_noraw
        assign raw_sel = 1'b0 & cfg.raw_add;
    end

    always_comb begin
        src     = cfg.xin ? acc_opp : acc_own;
        shifted = src >> cfg.shamt;
        high    = above_mask(cfg.top);
        picked  = shifted & span_mask(cfg.bot, cfg.top);
        if (cfg.sext && picked[cfg.top])
            picked = picked | high;
        contrib = raw_sel ? src : picked;
        result  = base + contrib;
        ovf     = |(shifted & high);
    end

endmodule

// File: rtl/interp2_regs.sv
module interp2_regs
    import interp2_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  bus_cmd_t             cmd,
    input  logic [DW-1:0]        wdata,
    input  logic [1:0][DW-1:0]   lane_res,
    output logic [1:0][DW-1:0]   acc,
    output logic [2:0][DW-1:0]   base,
    output lane_cfg_t [1:0]      cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            base <= '0;
            cfg  <= '0;
        end else begin
            for (int k = 0; k < 2; k++) begin
                if (cmd.acc_wr && (cmd.sel == 2'(k)))
                    acc[k] <= wdata;
                if (cmd.add_wr && (cmd.sel == 2'(k)))
                    acc[k] <= acc[k] + DW'(wdata[ADD_W-1:0]);
                if (cmd.pop)
                    acc[k] <= cfg[k].xres ? lane_res[1-k] : lane_res[k];
                if (cmd.cfg_wr && (cmd.sel == 2'(k)))
                    cfg[k] <= lane_cfg_t'(wdata[CFG_W-1:0]);
            end
            for (int b = 0; b < 3; b++) begin
                if (cmd.base_wr && (cmd.sel == 2'(b)))
                    base[b] <= wdata;
            end
            if (cmd.split_wr) begin
                base[0] <= DW'(wdata[HALF_W-1:0]);
                base[1] <= DW'(wdata[DW-1:HALF_W]);
            end
        end
    end

endmodule

// File: rtl/interp2_top.sv
module interp2_top
    import interp2_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata
);

    bus_cmd_t              cmd;
    logic [1:0][DW-1:0]    acc;
    logic [2:0][DW-1:0]    base;
    lane_cfg_t [1:0]       cfg;
    logic [1:0][DW-1:0]    contrib;
    logic [1:0][DW-1:0]    lane_res;
    logic [1:0][DW-1:0]    shown;
    logic [1:0]            ovf;
    logic [DW-1:0]         third;
    logic [DW-1:0]         status;
    logic [DW-1:0]         rd_mux;

    assign cmd = decode_req(req_valid, req_write, req_addr);

    interp2_regs #(.DW(DW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .wdata    (req_wdata),
        .lane_res (lane_res),
        .acc      (acc),
        .base     (base),
        .cfg      (cfg)
    );

    for (genvar k = 0; k < 2; k++) begin : g_lane
        interp2_lane #(.DW(DW), .RAW_OK(k == 0)) u_lane (
            .cfg     (cfg[k]),
            .acc_own (acc[k]),
            .acc_opp (acc[1-k]),
            .base    (base[k]),
            .contrib (contrib[k]),
            .result  (lane_res[k]),
            .ovf     (ovf[k])
        );
        assign shown[k] = lane_res[k] | (DW'(cfg[k].force_hi) << FORCE_POS);
    end

    assign third = base[2] + contrib[0] + contrib[1];

    always_comb begin
        status           = '0;
        status[OVF0_POS] = ovf[0];
        status[OVF1_POS] = ovf[1];
        status[OVFA_POS] = |ovf;
    end

    always_comb begin
        rd_mux = '0;
        unique case (reg_sel_e'(req_addr))
            A_ACC0, A_ADD0:   rd_mux = acc[0];
            A_ACC1, A_ADD1:   rd_mux = acc[1];
            A_BASE0:          rd_mux = base[0];
            A_BASE1:          rd_mux = base[1];
            A_BASE2:          rd_mux = base[2];
            A_POP0, A_PEEK0:  rd_mux = shown[0];
            A_POP1, A_PEEK1:  rd_mux = shown[1];
            A_POP2, A_PEEK2:  rd_mux = third;
            A_CFG0:           rd_mux = status | DW'(cfg[0]);
            A_CFG1:           rd_mux = status | DW'(cfg[1]);
            default:          rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid && !req_write;
            if (req_valid && !req_write)
                rsp_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/interp2_checker.sv
module interp2_checker #(
    parameter int DW = 32,
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_write,
    input logic [AW-1:0] req_addr,
    input logic [DW-1:0] req_wdata,
    input logic          rsp_valid,
    input logic [DW-1:0] acc0,
    input logic [DW-1:0] acc1,
    input logic [DW-1:0] base0,
    input logic [DW-1:0] base1,
    input logic [DW-1:0] res0,
    input logic [DW-1:0] res1,
    input logic          xres0,
    input logic          xres1
);

    logic is_read, is_pop, is_peek;
    assign is_read = req_valid && !req_write;
    assign is_pop  = is_read && (req_addr >= AW'(5)) && (req_addr <= AW'(7));
    assign is_peek = is_read && (req_addr >= AW'(8)) && (req_addr <= AW'(10));

    p_read_latency_r14: assert property (@(posedge clk) disable iff (rst)
        is_read |=> rsp_valid);

    p_idle_no_rsp_r14: assert property (@(posedge clk) disable iff (rst)
        !is_read |=> !rsp_valid);

    p_peek_holds_r10: assert property (@(posedge clk) disable iff (rst)
        is_peek |=> ($stable(acc0) && $stable(acc1)));

    p_pop_load_r10: assert property (@(posedge clk) disable iff (rst)
        (is_pop && !xres0 && !xres1) |=> (acc0 == $past(res0) && acc1 == $past(res1)));

    p_pop_cross_r6: assert property (@(posedge clk) disable iff (rst)
        (is_pop && xres0) |=> (acc0 == $past(res1)));

    p_add_port_r12: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_addr == AW'(13)) |=>
        (acc0 == $past(acc0) + DW'($past(req_wdata[23:0]))));

    p_base_pair_r13: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_addr == AW'(15)) |=>
        (base0 == DW'($past(req_wdata[15:0])) && base1 == DW'($past(req_wdata[31:16]))));

endmodule

bind interp2_top interp2_checker #(.DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .acc0      (acc[0]),
    .acc1      (acc[1]),
    .base0     (base[0]),
    .base1     (base[1]),
    .res0      (lane_res[0]),
    .res1      (lane_res[1]),
    .xres0     (cfg[0].xres),
    .xres1     (cfg[1].xres)
);

// File: tb/interp2_top_test.sv
module interp2_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [3:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int fails  = 0;

    logic [31:0] m_acc [2];
    logic [31:0] m_base[3];
    logic [31:0] m_cfg [2];

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    interp2_top uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    // ---------------- reference model ----------------
    function automatic logic [31:0] cfgw(int sh, int lo, int hi, bit sg, bit xi,
                                         bit xr, bit raw, int frc);
        return 32'(sh) | (32'(lo) << 5) | (32'(hi) << 10) | (32'(sg) << 15) |
               (32'(xi) << 16) | (32'(xr) << 17) | (32'(raw) << 18) | (32'(frc) << 19);
    endfunction

    function automatic logic [31:0] m_src(int k);
        return m_cfg[k][16] ? m_acc[1-k] : m_acc[k];
    endfunction

    function automatic logic [31:0] m_out(int k);
        logic [31:0] s, v;
        int sh, lo, hi;
        s  = m_src(k);
        sh = int'(m_cfg[k][4:0]);
        lo = int'(m_cfg[k][9:5]);
        hi = int'(m_cfg[k][14:10]);
        if (k == 0 && m_cfg[0][18]) return s;
        v = '0;
        for (int b = 0; b < 32; b++)
            if (b >= lo && b <= hi && (b + sh) < 32) v[b] = s[b + sh];
        if (m_cfg[k][15] && hi >= lo && v[hi])
            for (int b = 0; b < 32; b++) if (b > hi) v[b] = 1'b1;
        return v;
    endfunction

    function automatic bit m_ovf(int k);
        logic [31:0] s;
        int sh, hi;
        s  = m_src(k);
        sh = int'(m_cfg[k][4:0]);
        hi = int'(m_cfg[k][14:10]);
        for (int b = 0; b < 32; b++)
            if (b > hi && (b + sh) < 32 && s[b + sh]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [31:0] m_res(int k);
        return m_base[k] + m_out(k);
    endfunction

    function automatic logic [31:0] m_read(logic [3:0] a);
        logic [31:0] st;
        st = (32'(m_ovf(0)) << 23) | (32'(m_ovf(1)) << 24) | (32'(m_ovf(0) | m_ovf(1)) << 25);
        case (a)
            4'd0, 4'd13: return m_acc[0];
            4'd1, 4'd14: return m_acc[1];
            4'd2: return m_base[0];
            4'd3: return m_base[1];
            4'd4: return m_base[2];
            4'd5, 4'd8: return m_res(0) | (32'(m_cfg[0][20:19]) << 28);
            4'd6, 4'd9: return m_res(1) | (32'(m_cfg[1][20:19]) << 28);
            4'd7, 4'd10: return m_base[2] + m_out(0) + m_out(1);
            4'd11: return (m_cfg[0] & 32'h001F_FFFF) | st;
            4'd12: return (m_cfg[1] & 32'h001F_FFFF) | st;
            default: return 32'h0;
        endcase
    endfunction

    // ---------------- driver ----------------
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        case (a)
            4'd0: m_acc[0] = d;
            4'd1: m_acc[1] = d;
            4'd2: m_base[0] = d;
            4'd3: m_base[1] = d;
            4'd4: m_base[2] = d;
            4'd11: m_cfg[0] = d & 32'h001F_FFFF;
            4'd12: m_cfg[1] = d & 32'h001F_FFFF;
            4'd13: m_acc[0] = m_acc[0] + {8'h0, d[23:0]};
            4'd14: m_acc[1] = m_acc[1] + {8'h0, d[23:0]};
            4'd15: begin m_base[0] = {16'h0, d[15:0]}; m_base[1] = {16'h0, d[31:16]}; end
            default: ;
        endcase
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input string tag);
        logic [31:0] r0, r1;
        exp_q.push_back(m_read(a));
        tag_q.push_back(tag);
        if (a >= 4'd5 && a <= 4'd7) begin
            r0 = m_res(0);
            r1 = m_res(1);
            m_acc[0] = m_cfg[0][17] ? r1 : r0;
            m_acc[1] = m_cfg[1][17] ? r0 : r1;
        end
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = '0;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- monitor ----------------
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R14 unexpected response actual=%h expected=none", rsp_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(rsp_rdata, e, t);
            end
        end
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL R14 watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        for (int i = 0; i < 2; i++) begin m_acc[i] = '0; m_cfg[i] = '0; end
        for (int i = 0; i < 3; i++) m_base[i] = '0;
        repeat (3) @(negedge clk);
        chk({31'h0, rsp_valid}, 32'h0, "R1 rsp_valid in reset");
        rst = 1'b0;

        // R1: everything reads zero after reset
        for (int a = 0; a < 16; a++) rd(4'(a), "R1 reset readback");

        // R2: plain register access
        wr(4'd0, 32'hDEAD_BEEF); wr(4'd1, 32'h0123_4567);
        wr(4'd2, 32'hAAAA_5555); wr(4'd3, 32'h1357_9BDF); wr(4'd4, 32'hF0F0_0F0F);
        for (int a = 0; a < 5; a++) rd(4'(a), "R2 acc/base readback");
        wr(4'd11, 32'hFFFF_FFFF); rd(4'd11, "R2 cfg0 reserved bits");
        wr(4'd12, 32'h0000_0000); rd(4'd12, "R2 cfg1 readback");
        rd(4'd13, "R2 add port read"); rd(4'd15, "R2 base pair read");

        // R3: shift and mask patterns
        wr(4'd0, 32'h1234_5678); wr(4'd2, 32'h0000_1000);
        wr(4'd11, cfgw(4, 4, 11, 0, 0, 0, 0, 0)); rd(4'd8, "R3 shift4 bits4..11");
        wr(4'd11, cfgw(0, 0, 31, 0, 0, 0, 0, 0)); rd(4'd8, "R3 full mask");
        wr(4'd11, cfgw(31, 0, 31, 0, 0, 0, 0, 0)); rd(4'd8, "R3 shift31");
        wr(4'd11, cfgw(0, 9, 3, 0, 0, 0, 0, 0));  rd(4'd8, "R3 empty mask");
        wr(4'd2, 32'hFFFF_FFFF); wr(4'd11, cfgw(0, 0, 7, 0, 0, 0, 0, 0));
        rd(4'd8, "R3 base wraps");

        // R4: sign extension
        wr(4'd2, 32'h0); wr(4'd0, 32'h0000_00F0);
        wr(4'd11, cfgw(4, 0, 3, 1, 0, 0, 0, 0)); rd(4'd8, "R4 negative field");
        wr(4'd0, 32'h0000_0070); rd(4'd8, "R4 positive field");
        wr(4'd11, cfgw(4, 0, 3, 0, 0, 0, 0, 0)); wr(4'd0, 32'h0000_00F0);
        rd(4'd8, "R4 unsigned field");

        // R5: cross input
        wr(4'd0, 32'h0000_0011); wr(4'd1, 32'h0000_0F00);
        wr(4'd12, cfgw(8, 0, 7, 0, 1, 0, 0, 0)); rd(4'd9, "R5 lane1 takes acc0");
        wr(4'd11, cfgw(8, 0, 7, 0, 1, 0, 0, 0)); rd(4'd8, "R5 lane0 takes acc1");

        // R10 / R6: pop and peek
        wr(4'd11, cfgw(0, 0, 31, 0, 0, 0, 0, 0)); wr(4'd12, cfgw(0, 0, 31, 0, 0, 0, 0, 0));
        wr(4'd0, 32'd10); wr(4'd1, 32'd100); wr(4'd2, 32'd1); wr(4'd3, 32'd2);
        rd(4'd8, "R10 peek"); rd(4'd0, "R10 peek left acc0"); rd(4'd1, "R10 peek left acc1");
        rd(4'd5, "R10 pop returns old result");
        rd(4'd0, "R10 pop loaded acc0"); rd(4'd1, "R10 pop loaded acc1");
        rd(4'd6, "R10 pop lane1"); rd(4'd6, "R10 back-to-back pop");
        wr(4'd11, cfgw(0, 0, 31, 0, 0, 1, 0, 0));
        rd(4'd7, "R6 pop with cross result");
        rd(4'd0, "R6 acc0 from lane1"); rd(4'd1, "R6 acc1 own");

        // R7: raw add
        wr(4'd0, 32'hCAFE_0001); wr(4'd1, 32'hCAFE_0001);
        wr(4'd11, cfgw(8, 0, 3, 0, 0, 0, 1, 0)); wr(4'd12, cfgw(8, 0, 3, 0, 0, 0, 1, 0));
        rd(4'd8, "R7 lane0 raw"); rd(4'd9, "R7 lane1 ignores raw");

        // R8: forced high bits on bus only
        wr(4'd11, cfgw(0, 0, 15, 0, 0, 0, 0, 3)); wr(4'd12, cfgw(0, 0, 15, 0, 0, 0, 0, 1));
        rd(4'd8, "R8 force lane0"); rd(4'd9, "R8 force lane1");
        rd(4'd10, "R8 no force on result2");
        rd(4'd5, "R8 pop forced"); rd(4'd0, "R8 writeback unforced acc0");
        rd(4'd1, "R8 writeback unforced acc1");

        // R9: overflow flags
        wr(4'd0, 32'h0000_0100); wr(4'd1, 32'h0000_0001);
        wr(4'd11, cfgw(0, 0, 7, 0, 0, 0, 0, 0)); wr(4'd12, cfgw(0, 0, 7, 0, 0, 0, 0, 0));
        rd(4'd11, "R9 lane0 overflow"); rd(4'd12, "R9 seen from lane1 cfg");
        wr(4'd11, cfgw(1, 0, 6, 0, 0, 0, 0, 0)); rd(4'd11, "R9 shifted out");
        wr(4'd0, 32'h0); wr(4'd1, 32'h8000_0000); rd(4'd12, "R9 lane1 overflow");

        // R11: third result
        wr(4'd0, 32'h0000_0F0F); wr(4'd1, 32'hFFFF_FF00); wr(4'd4, 32'h8000_0000);
        wr(4'd11, cfgw(4, 0, 7, 1, 0, 0, 0, 0)); wr(4'd12, cfgw(8, 0, 23, 0, 0, 0, 0, 0));
        rd(4'd10, "R11 sum of lane outputs"); rd(4'd7, "R11 pop result2");

        // R12: add ports
        wr(4'd0, 32'hFFFF_FFF0); wr(4'd13, 32'hFF00_0020); rd(4'd0, "R12 wrap, upper ignored");
        wr(4'd1, 32'h0000_0005); wr(4'd14, 32'h00FF_FFFF); rd(4'd1, "R12 max add");

        // R13: paired base write
        wr(4'd15, 32'h89AB_CDEF); rd(4'd2, "R13 base0 low half"); rd(4'd3, "R13 base1 high half");
        rd(4'd4, "R13 base2 untouched");

        // R14: write cycle returns nothing
        wr(4'd2, 32'h5);
        chk({31'h0, rsp_valid}, 32'h0, "R14 no response to write");

        // mixed traffic
        for (int n = 0; n < 400; n++) begin
            logic [3:0] a;
            a = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 1) == 1) wr(a, $urandom());
            else rd(a, "R10 mixed traffic");
        end

        repeat (3) @(negedge clk);
        chk(32'(exp_q.size()), 32'h0, "R14 all reads answered");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule